// File: doc/BRIEF.md
# Three-Strobe ADC Host Sequencer

This block runs the host side of a parallel-output successive-approximation converter. The converter is controlled by one chip-select strobe and one read/convert level. A start request sends three chip-select falling edges in turn. The first edge powers the converter up and begins acquisition. The second edge freezes the sample and starts conversion; the read/convert level on that edge chooses whether the reference stays powered afterwards (standby) or shuts down. The third edge, issued only after end-of-conversion has fallen, puts the result on the bus.

In byte-wide mode the third strobe holds chip-select low for two reads. The high-byte enable is low for the first read, which returns the lower byte. It is high for the second read, which returns the upper six result bits. Every delay is a parameter counted in system-clock cycles.

The converter's reference needs time to settle after it wakes, and the converter may wake in an unknown state. For this reason, any request made after reset, after a shutdown-mode conversion or after a timeout first runs a long-acquisition dummy conversion and discards its result. The 14-bit unsigned result comes out with a one-cycle valid strobe. A busy output covers the whole cycle, including the bus-relinquish wait.

Top module: `adc_strobe_seq`

## Requirements
- R1: While reset is held, chip-select and read/convert are high, high-byte enable is low, busy and valid are low and the result is zero.
- R2: The first falling edge of chip-select in a conversion has read/convert low, and read/convert has not changed in the cycle of any chip-select falling edge.
- R3: With the converter awake, the second falling edge comes exactly ACQ_CYC cycles after the first. Read/convert on it equals the low-power input captured at start (1 = shut the reference down, 0 = standby).
- R4: The read strobe has read/convert high and falls only after end-of-conversion was sampled low. In word mode the result equals the 14-bit bus sampled DV_CYC cycles after that fall.
- R5: In byte mode, bus bits 7:0 are read with high-byte enable 0, then bus bits 5:0 with enable 1. The result is {upper[5:0], lower[7:0]}, and high-byte enable is high only while chip-select is low.
- R6: Every chip-select low pulse lasts at least PW_CYC cycles.
- R7: valid is a single-cycle pulse raised once per request. busy stays high for exactly BR_CYC cycles counted from the valid cycle, and a start request while busy is ignored.
- R8: A request after reset or after a shutdown-mode conversion first runs a dummy conversion. Its acquisition lasts SETTLE_CYC cycles, its second edge has read/convert low, and no valid is raised for it. The normal conversion follows, so the request makes six falling edges.
- R9: A request after a standby-mode conversion makes exactly three falling edges.
- R10: If end-of-conversion does not fall within EOC_TMO cycles, timeout pulses for one cycle, the sequencer returns to idle with chip-select high and no valid, and the next request begins with a dummy conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, taken when idle |
| low_power_i | input | 1 | 1 = shut the reference down after conversion |
| byte_mode_i | input | 1 | 1 = two byte reads, 0 = one 14-bit read |
| eoc_n_i | input | 1 | End-of-conversion from the converter, active low |
| bus_i | input | 14 | Converter data bus |
| cs_n_o | output | 1 | Chip-select to the converter, active low |
| rdc_o | output | 1 | Read/convert level to the converter |
| hben_o | output | 1 | High-byte enable to the converter |
| result_o | output | 14 | Last result, unsigned straight binary |
| valid_o | output | 1 | One-cycle pulse when result_o is updated |
| busy_o | output | 1 | High from an accepted start to the end of relinquish |
| timeout_o | output | 1 | One-cycle pulse on end-of-conversion timeout |

## Verification
A wrong state in the strobe sequencer shows on chip-select within one pulse. It appears as a wrong count of falling edges per request, a wrong read/convert level on an edge, or a wrong gap between the first two edges. If the sleep flag is wrong, the number of falling edges in the next request changes from three to six or the other way round. A fault in byte assembly or sample timing shows as a wrong result on the single valid pulse of the same request. A wrong relinquish count shows as a busy tail of the wrong length right after that pulse.

// File: rtl/adc_strobe_seq.sv
module adc_strobe_seq #(
  parameter int SU_CYC     = 2,
  parameter int PW_CYC     = 3,
  parameter int ACQ_CYC    = 12,
  parameter int SETTLE_CYC = 40,
  parameter int DV_CYC     = 4,
  parameter int BR_CYC     = 5,
  parameter int EOC_TMO    = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        low_power_i,
  input  logic        byte_mode_i,
  input  logic        eoc_n_i,
  input  logic [13:0] bus_i,
  output logic        cs_n_o,
  output logic        rdc_o,
  output logic        hben_o,
  output logic [13:0] result_o,
  output logic        valid_o,
  output logic        busy_o,
  output logic        timeout_o
);
  localparam int MAXC = (SETTLE_CYC > EOC_TMO) ? SETTLE_CYC : EOC_TMO;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SU_LAST  = CW'(SU_CYC - 1);
  localparam logic [CW-1:0] PW_LAST  = CW'(PW_CYC - 1);
  localparam logic [CW-1:0] ACQ_LAST = CW'(ACQ_CYC - 1);
  localparam logic [CW-1:0] SET_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] DV_LAST  = CW'(DV_CYC - 1);
  localparam logic [CW-1:0] BR_LAST  = CW'(BR_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST = CW'(EOC_TMO - 1);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_ACQ, S_CNV, S_EOC, S_RD, S_REL} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          lp_q, bm_q, dummy_q, asleep_q;
  logic [7:0]    lo_q;
  logic [CW-1:0] acq_last;

  assign acq_last = dummy_q ? SET_LAST : ACQ_LAST;
  assign busy_o   = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      cs_n_o    <= 1'b1;
      rdc_o     <= 1'b1;
      hben_o    <= 1'b0;
      result_o  <= '0;
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
      lp_q      <= 1'b0;
      bm_q      <= 1'b0;
      dummy_q   <= 1'b0;
      asleep_q  <= 1'b1;
      lo_q      <= '0;
    end else begin
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          lp_q    <= low_power_i;
          bm_q    <= byte_mode_i;
          dummy_q <= asleep_q;
          rdc_o   <= 1'b0;
          cnt     <= '0;
          state   <= S_ARM;
        end
        S_ARM: if (cnt == SU_LAST) begin
          cs_n_o <= 1'b0;
          cnt    <= '0;
          state  <= S_ACQ;
        end else cnt <= cnt + 1'b1;
        S_ACQ: begin
          if (cnt == PW_LAST) begin
            cs_n_o <= 1'b1;
            rdc_o  <= lp_q & ~dummy_q;
          end
          if (cnt == acq_last) begin
            cs_n_o <= 1'b0;
            cnt    <= '0;
            state  <= S_CNV;
          end else cnt <= cnt + 1'b1;
        end
        S_CNV: if (cnt == PW_LAST) begin
          cs_n_o <= 1'b1;
          rdc_o  <= 1'b1;
          cnt    <= '0;
          state  <= S_EOC;
        end else cnt <= cnt + 1'b1;
        S_EOC: if (!eoc_n_i && cnt >= SU_LAST) begin
          cs_n_o <= 1'b0;
          hben_o <= 1'b0;
          cnt    <= '0;
          state  <= S_RD;
        end else if (cnt == TMO_LAST) begin
          timeout_o <= 1'b1;
          asleep_q  <= 1'b1;
          dummy_q   <= 1'b0;
          cnt       <= '0;
          state     <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        S_RD: if (cnt == DV_LAST) begin
          cnt <= '0;
          if (bm_q && !hben_o) begin
            lo_q   <= bus_i[7:0];
            hben_o <= 1'b1;
          end else begin
            cs_n_o <= 1'b1;
            hben_o <= 1'b0;
            state  <= S_REL;
            if (!dummy_q) begin
              valid_o  <= 1'b1;
              result_o <= bm_q ? {bus_i[5:0], lo_q} : bus_i;
              asleep_q <= lp_q;
            end
          end
        end else cnt <= cnt + 1'b1;
        S_REL: if (cnt == BR_LAST) begin
          cnt <= '0;
          if (dummy_q) begin
            dummy_q <= 1'b0;
            rdc_o   <= 1'b0;
            state   <= S_ARM;
          end else state <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_strobe_seq_chk.sv
module adc_strobe_seq_chk #(
  parameter int PW_CYC = 3
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n_o,
  input logic rdc_o,
  input logic hben_o,
  input logic eoc_n_i,
  input logic valid_o,
  input logic busy_o,
  input logic timeout_o
);
  logic [15:0] lowcnt;
  logic        cs_prev;
  logic [1:0]  ph;
  logic        fell_s;

  assign fell_s = cs_prev & ~cs_n_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lowcnt  <= '0;
      cs_prev <= 1'b1;
      ph      <= '0;
    end else begin
      cs_prev <= cs_n_o;
      if (cs_n_o) lowcnt <= '0;
      else if (lowcnt != 16'hFFFF) lowcnt <= lowcnt + 16'd1;
      if (timeout_o) ph <= '0;
      else if (fell_s) ph <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
    end
  end

  p_idle_cs_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cs_n_o && !hben_o));
  p_rdc_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> $stable(rdc_o));
  p_read_after_eoc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fell_s && ph == 2'd2) |-> (rdc_o && !$past(eoc_n_i)));
  p_hben_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hben_o |-> !cs_n_o);
  p_pulse_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> (lowcnt >= 16'(PW_CYC)));
  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_valid_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> busy_o);
  p_timeout_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (!busy_o && cs_n_o && !valid_o));
endmodule

bind adc_strobe_seq adc_strobe_seq_chk #(.PW_CYC(PW_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n_o(cs_n_o), .rdc_o(rdc_o), .hben_o(hben_o),
  .eoc_n_i(eoc_n_i), .valid_o(valid_o), .busy_o(busy_o), .timeout_o(timeout_o)
);

// File: tb/adc_strobe_seq_tb_top.sv
module adc_strobe_seq_tb_top;
  localparam int CLK_P      = 10;
  localparam int SU_CYC     = 2;
  localparam int PW_CYC     = 3;
  localparam int ACQ_CYC    = 12;
  localparam int SETTLE_CYC = 40;
  localparam int DV_CYC     = 4;
  localparam int BR_CYC     = 5;
  localparam int EOC_TMO    = 64;
  localparam int CONV_CYC   = 20;
  localparam logic [13:0] DUMMY_W = 14'h0DEF;

  // {byte_mode, low_power, word[13:0], expect_dummy}
  localparam logic [16:0] VEC [0:6] = '{
    {1'b0, 1'b0, 14'h1234, 1'b1},
    {1'b0, 1'b1, 14'h3FFF, 1'b0},
    {1'b1, 1'b0, 14'h2A5C, 1'b1},
    {1'b1, 1'b0, 14'h0001, 1'b0},
    {1'b1, 1'b1, 14'h3F80, 1'b0},
    {1'b0, 1'b0, 14'h0000, 1'b1},
    {1'b0, 1'b0, 14'h2001, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, lp = 1'b0, bm = 1'b0, eoc_n = 1'b1;
  logic [13:0] bus = '0;
  logic cs_n, rdc, hben, valid, busy, tmo;
  logic [13:0] result;

  always #(CLK_P/2) clk = ~clk;

  adc_strobe_seq #(.SU_CYC(SU_CYC), .PW_CYC(PW_CYC), .ACQ_CYC(ACQ_CYC),
    .SETTLE_CYC(SETTLE_CYC), .DV_CYC(DV_CYC), .BR_CYC(BR_CYC), .EOC_TMO(EOC_TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .low_power_i(lp), .byte_mode_i(bm),
    .eoc_n_i(eoc_n), .bus_i(bus), .cs_n_o(cs_n), .rdc_o(rdc), .hben_o(hben),
    .result_o(result), .valid_o(valid), .busy_o(busy), .timeout_o(tmo));

  int checks = 0, errors = 0;
  int cyc = 0, nfall = 0, nval = 0, ntmo = 0, tail = 0, phase_m = 0, timer = 0, conv_n = 0;
  int lowrun = 0, minlow = 1000;
  int stamp [0:7];
  bit rdcv [0:7];
  bit reading = 0, hang = 0, tail_on = 0, ed = 0, prev_cs = 1;
  logic [13:0] word = '0, cap = '0, wsel;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !cs_n) begin
      if (nfall < 8) begin stamp[nfall] = cyc; rdcv[nfall] = rdc; end
      nfall++;
      if (phase_m == 1) begin phase_m = 2; conv_n++; timer = CONV_CYC; end
      else if (!rdc) phase_m = 1;
      else if (phase_m == 2) reading = 1;
    end
    if (!prev_cs && cs_n) begin
      if (lowrun < minlow) minlow = lowrun;
      lowrun = 0;
      if (reading) begin reading = 0; eoc_n = 1'b1; phase_m = 0; end
    end
    if (!cs_n) lowrun++;
    if (timer > 0) begin timer--; if (timer == 0 && !hang) eoc_n = 1'b0; end
    prev_cs = cs_n;
    wsel = (ed && conv_n == 1) ? DUMMY_W : word;
    if (reading) bus = bm ? (hben ? {6'h2A, 2'b00, wsel[13:8]} : {6'h15, wsel[7:0]}) : wsel;
    else bus = 14'h1555;
    if (tmo) ntmo++;
    if (valid) begin nval++; cap = result; tail = 0; tail_on = 1; end
    if (tail_on) begin if (busy) tail++; else tail_on = 0; end
  end

  task automatic run(input bit b, input bit l, input logic [13:0] w, input bit d);
    int o;
    bm = b; lp = l; word = w; ed = d;
    nfall = 0; nval = 0; conv_n = 0; tail = 0; ntmo = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    o = d ? 3 : 0;
    check(nfall == (d ? 6 : 3), d ? "R8 edge count" : "R9 edge count", nfall, d ? 6 : 3);
    if (d) begin
      check(stamp[1] - stamp[0] == SETTLE_CYC, "R8 settle gap", stamp[1] - stamp[0], SETTLE_CYC);
      check({rdcv[0], rdcv[1], rdcv[2]} == 3'b001, "R8 dummy levels",
            {rdcv[0], rdcv[1], rdcv[2]}, 1);
    end
    check(rdcv[o] == 1'b0, "R2 first edge level", rdcv[o], 0);
    check(stamp[o+1] - stamp[o] == ACQ_CYC, "R3 acquire gap", stamp[o+1] - stamp[o], ACQ_CYC);
    check(rdcv[o+1] == l, "R3 mode level", rdcv[o+1], l);
    check(rdcv[o+2] == 1'b1, "R4 read level", rdcv[o+2], 1);
    check(nval == 1, "R7 valid count", nval, 1);
    check(cap == w, b ? "R5 byte result" : "R4 word result", cap, w);
    check(tail == BR_CYC, "R7 busy tail", tail, BR_CYC);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=finished", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1 && rdc == 1'b1 && hben == 1'b0, "R1 strobe levels", {cs_n, rdc, hben}, 3'b110);
    check(busy == 1'b0 && valid == 1'b0 && tmo == 1'b0, "R1 flags", {busy, valid, tmo}, 0);
    check(result == 14'h0, "R1 result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      logic [16:0] v;
      v = VEC[i];
      run(v[16], v[15], v[14:1], v[0]);
    end

    // R7: start while busy ignored
    bm = 1'b0; lp = 1'b0; word = 14'h0F0F; ed = 1'b0;
    nfall = 0; nval = 0; conv_n = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (15) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (busy) @(negedge clk);
    repeat (30) @(negedge clk);
    check(nfall == 3, "R7 start while busy ignored", nfall, 3);
    check(busy == 1'b0 && nval == 1, "R7 single result", {busy, 8'(nval)}, 1);

    // R10: end-of-conversion never falls
    hang = 1'b1; nfall = 0; nval = 0; ntmo = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    check(ntmo == 1, "R10 timeout pulse", ntmo, 1);
    check(nval == 0 && cs_n == 1'b1, "R10 idle no valid", {nval[7:0], cs_n}, 1);
    check(nfall == 2, "R10 edges before timeout", nfall, 2);
    hang = 1'b0;
    run(1'b0, 1'b0, 14'h1ABC, 1'b1);

    check(minlow >= PW_CYC, "R6 chip-select low width", minlow, PW_CYC);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule